// File: doc/BRIEF.md
# Random Early Drop Admission Decider

This block decides, for each packet arriving at one output queue, whether the packet is admitted or discarded. It keeps a smoothed, exponentially weighted average of the queue occupancy. It compares that average against two programmable thresholds, a lower and an upper one. Below the lower threshold nothing is discarded. Above the upper threshold everything is discarded. Between the two, packets are discarded at random, with a probability that rises linearly from zero to one. Discarding therefore starts before the queue is full. Because the decision follows the average and not the instantaneous length, a short burst that briefly lengthens the queue still gets through.

The queue manager presents the current queue length together with a one-cycle arrival strobe. The verdict appears one clock cycle later. The random value comes from an internal 16-bit linear feedback shift register, which steps once for each arrival. If the thresholds are programmed so that the lower one is not below the upper one, the block falls back to plain tail discard at the upper threshold.

Top module: `red_drop_decider`

## Requirements
- R1: `dec_valid` is high in exactly the cycle after each cycle with `arr_valid` high, and low otherwise. `dec_drop` is never high while `dec_valid` is low.
- R2: The average is unsigned fixed point with 8 fractional bits. On each arrival it becomes `avg + ((q_len*256 - avg) >>> avg_shift)`, where `>>>` is an arithmetic (flooring) shift. It is held unchanged in cycles without an arrival. With `avg_shift` = 0 the new average equals `q_len*256`.
- R3: Synchronous active-high reset clears the average to zero, loads the random register with 16'hACE1, and drives both outputs low.
- R4: An arrival with `q_len` = 0 is always admitted, whatever the configuration.
- R5: With `thr_lo < thr_hi` and a non-zero `q_len`, an arrival whose updated average is below `thr_lo*256` is admitted.
- R6: With `thr_lo < thr_hi` and a non-zero `q_len`, an arrival whose updated average is at or above `thr_hi*256` is discarded.
- R7: With `thr_lo < thr_hi` and `thr_lo*256 <= avg < thr_hi*256`, where avg is the updated average, the packet is discarded exactly when `r*((thr_hi-thr_lo)*256) < (avg - thr_lo*256)*65536`. Here r is the random register value before this arrival steps it. An average equal to `thr_lo*256` therefore never discards.
- R8: The random register is a right-shifting Galois register with next value `(s >> 1) ^ (s[0] ? 16'hB400 : 0)`. It steps once per arrival, never in cycles without an arrival, and never holds zero.
- R9: When `thr_lo >= thr_hi`, a packet with non-zero `q_len` is discarded exactly when `q_len >= thr_hi`. The average plays no part in the verdict.
- R10: The verdict uses the updated average, not `q_len`. A few back-to-back arrivals with a long queue are admitted while the average is still below `thr_lo*256`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arr_valid | input | 1 | One packet arrives in this cycle |
| q_len | input | QW | Instantaneous queue length in packets |
| thr_lo | input | QW | Lower threshold; discarding starts above it |
| thr_hi | input | QW | Upper threshold; everything is discarded at and above it |
| avg_shift | input | SHW | Averaging weight as a right shift (weight 2^-avg_shift) |
| dec_valid | output | 1 | Verdict for the previous cycle's arrival is present |
| dec_drop | output | 1 | 1 = discard, 0 = admit; meaningful with dec_valid |

## Verification
Isolated arrivals with a zero averaging shift make the average equal the instantaneous length. This pins each region boundary exactly: empty queue, below the lower threshold, equal to it, inside the ramp, equal to the upper threshold, and above it. It also covers both orderings of a misordered threshold pair, which tells the ramp and tail fallback paths apart. Inside the ramp, each verdict is compared with an independent model of the average and the random register. Idle cycles between arrivals expose a register that steps when it should not. A long run at the midpoint of the ramp checks that the discard fraction lands near one half. Back-to-back arrivals with a large shift and a long queue show that a burst is admitted on the average, and that the average starts from zero after reset.

// File: rtl/red_pkg.sv
package red_pkg;

    // Fractional bits of the occupancy average.
    localparam int FRAC_W = 8;

    // Random source: 16-bit right-shifting Galois register.
    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_TAPS = 16'hB400;
    localparam logic [15:0] RND_SEED = 16'hACE1;

    // Where the current arrival falls relative to the programmed curve.
    typedef enum logic [2:0] {
        ZONE_EMPTY = 3'd0,   // queue empty, always admitted
        ZONE_LOW   = 3'd1,   // average below lower threshold
        ZONE_RAMP  = 3'd2,   // probabilistic region
        ZONE_HIGH  = 3'd3,   // average at or above upper threshold
        ZONE_TAIL  = 3'd4    // thresholds misordered, tail rule applies
    } zone_e;

    typedef struct packed {
        zone_e zone;
        logic  ramp_hit;     // random comparison result in the ramp
        logic  tail_hit;     // instantaneous length at or above upper threshold
    } verdict_t;

    function automatic logic zone_drops(input verdict_t v);
        logic d;
        unique case (v.zone)
            ZONE_EMPTY: d = 1'b0;
            ZONE_LOW:   d = 1'b0;
            ZONE_RAMP:  d = v.ramp_hit;
            ZONE_HIGH:  d = 1'b1;
            ZONE_TAIL:  d = v.tail_hit;
            default:    d = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/red_rand_src.sv
module red_rand_src #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value
);

    logic [W-1:0] load_val;
    logic [W-1:0] next_val;

    // A zero seed would lock the register; substitute one.
    generate
        if (SEED == '0) begin : g_seed_fix
            assign load_val = W'(1);
        end else begin : g_seed_ok
            assign load_val = SEED;
        end
    endgenerate

    always_comb begin
        next_val = value >> 1;
        if (value[0]) begin
            next_val = next_val ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= load_val;
        end else if (step) begin
            value <= next_val;
        end
    end

endmodule

// File: rtl/red_avg_filter.sv
module red_avg_filter #(
    parameter int QW   = 16,
    parameter int FW   = 8,
    parameter int SHW  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  logic [QW-1:0]   q_len,
    input  logic [SHW-1:0]  shift,
    output logic [QW+FW-1:0] avg_cur,
    output logic [QW+FW-1:0] avg_new
);

    localparam int AW = QW + FW;

    logic [AW-1:0]        q_fp;
    logic signed [AW:0]   diff;
    logic signed [AW:0]   step;
    logic signed [AW:0]   sum;
    logic                 sum_unused_msb;

    assign q_fp = {q_len, {FW{1'b0}}};

    always_comb begin
        diff = $signed({1'b0, q_fp}) - $signed({1'b0, avg_cur});
        step = diff >>> shift;
        sum  = $signed({1'b0, avg_cur}) + step;
    end

    // The sum stays between the old average and q_fp, so the top bit is zero.
    assign {sum_unused_msb, avg_new} = sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            avg_cur <= '0;
        end else if (upd) begin
            avg_cur <= avg_new;
        end
    end

endmodule

// File: rtl/red_zone_eval.sv
module red_zone_eval
    import red_pkg::*;
#(
    parameter int QW = 16,
    parameter int FW = 8,
    parameter int RW = 16
) (
    input  logic [QW-1:0]    q_len,
    input  logic [QW-1:0]    thr_lo,
    input  logic [QW-1:0]    thr_hi,
    input  logic [QW+FW-1:0] avg,
    input  logic [RW-1:0]    rnd,
    output verdict_t         verdict
);

    localparam int AW = QW + FW;
    localparam int PW = AW + RW;

    logic [AW-1:0] lo_fp;
    logic [AW-1:0] hi_fp;
    logic [AW-1:0] span;
    logic [AW-1:0] excess;
    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;
    logic          cfg_ok;

    assign lo_fp  = {thr_lo, {FW{1'b0}}};
    assign hi_fp  = {thr_hi, {FW{1'b0}}};
    assign cfg_ok = thr_lo < thr_hi;
    assign span   = hi_fp - lo_fp;
    assign excess = avg - lo_fp;

    // Multiply instead of divide: r/2^RW < excess/span.
    assign lhs = PW'(rnd) * PW'(span);
    assign rhs = {excess, {RW{1'b0}}};

    always_comb begin
        verdict.ramp_hit = lhs < rhs;
        verdict.tail_hit = q_len >= thr_hi;
        if (q_len == '0) begin
            verdict.zone = ZONE_EMPTY;
        end else if (!cfg_ok) begin
            verdict.zone = ZONE_TAIL;
        end else if (avg < lo_fp) begin
            verdict.zone = ZONE_LOW;
        end else if (avg >= hi_fp) begin
            verdict.zone = ZONE_HIGH;
        end else begin
            verdict.zone = ZONE_RAMP;
        end
    end

endmodule

// File: rtl/red_drop_decider.sv
module red_drop_decider
    import red_pkg::*;
#(
    parameter int QW  = 16,
    parameter int SHW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arr_valid,
    input  logic [QW-1:0]  q_len,
    input  logic [QW-1:0]  thr_lo,
    input  logic [QW-1:0]  thr_hi,
    input  logic [SHW-1:0] avg_shift,
    output logic           dec_valid,
    output logic           dec_drop
);

    localparam int AW = QW + FRAC_W;

    logic [AW-1:0]    avg_cur;
    logic [AW-1:0]    avg_new;
    logic [RND_W-1:0] rnd;
    verdict_t         verdict;

    red_avg_filter #(
        .QW  (QW),
        .FW  (FRAC_W),
        .SHW (SHW)
    ) avg_i (
        .clk     (clk),
        .rst     (rst),
        .upd     (arr_valid),
        .q_len   (q_len),
        .shift   (avg_shift),
        .avg_cur (avg_cur),
        .avg_new (avg_new)
    );

    red_rand_src #(
        .W    (RND_W),
        .TAPS (RND_TAPS),
        .SEED (RND_SEED)
    ) rand_i (
        .clk   (clk),
        .rst   (rst),
        .step  (arr_valid),
        .value (rnd)
    );

    red_zone_eval #(
        .QW (QW),
        .FW (FRAC_W),
        .RW (RND_W)
    ) zone_i (
        .q_len   (q_len),
        .thr_lo  (thr_lo),
        .thr_hi  (thr_hi),
        .avg     (avg_new),
        .rnd     (rnd),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            dec_drop  <= 1'b0;
        end else begin
            dec_valid <= arr_valid;
            dec_drop  <= arr_valid & zone_drops(verdict);
        end
    end

endmodule

// File: rtl/red_drop_decider_chk.sv
module red_drop_decider_chk #(
    parameter int QW = 16,
    parameter int FW = 8,
    parameter int RW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             arr_valid,
    input logic [QW-1:0]    q_len,
    input logic [QW-1:0]    thr_lo,
    input logic [QW-1:0]    thr_hi,
    input logic             dec_valid,
    input logic             dec_drop,
    input logic [QW+FW-1:0] avg_cur,
    input logic [QW+FW-1:0] avg_new,
    input logic [RW-1:0]    rnd
);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        arr_valid |=> dec_valid);

    a_r1_valid_quiet: assert property (@(posedge clk) disable iff (rst)
        !arr_valid |=> !dec_valid);

    a_r1_drop_needs_valid: assert property (@(posedge clk) disable iff (rst)
        dec_drop |-> dec_valid);

    a_r2_avg_hold: assert property (@(posedge clk) disable iff (rst)
        !arr_valid |=> $stable(avg_cur));

    a_r4_empty_admit: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && q_len == '0) |=> !dec_drop);

    a_r5_below_admit: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && q_len != '0 && thr_lo < thr_hi &&
         avg_new < {thr_lo, {FW{1'b0}}}) |=> !dec_drop);

    a_r6_above_drop: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && q_len != '0 && thr_lo < thr_hi &&
         avg_new >= {thr_hi, {FW{1'b0}}}) |=> dec_drop);

    a_r8_rand_nonzero: assert property (@(posedge clk) disable iff (rst)
        rnd != '0);

    a_r8_rand_hold: assert property (@(posedge clk) disable iff (rst)
        !arr_valid |=> $stable(rnd));

    a_r9_tail_rule: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && q_len != '0 && !(thr_lo < thr_hi)) |=> (dec_drop == $past(q_len >= thr_hi)));

endmodule

bind red_drop_decider red_drop_decider_chk #(
    .QW (QW),
    .FW (red_pkg::FRAC_W),
    .RW (red_pkg::RND_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .arr_valid (arr_valid),
    .q_len     (q_len),
    .thr_lo    (thr_lo),
    .thr_hi    (thr_hi),
    .dec_valid (dec_valid),
    .dec_drop  (dec_drop),
    .avg_cur   (avg_cur),
    .avg_new   (avg_new),
    .rnd       (rnd)
);

// File: tb/red_drop_decider_tb_top.sv
module red_drop_decider_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QW  = 16;
    localparam int SHW = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           arr_valid = 1'b0;
    logic [QW-1:0]  q_len = '0;
    logic [QW-1:0]  thr_lo = '0;
    logic [QW-1:0]  thr_hi = '0;
    logic [SHW-1:0] avg_shift = '0;
    logic           dec_valid;
    logic           dec_drop;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Reference state built from the requirements.
    longint   m_avg = 0;
    bit [15:0] m_rnd = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    red_drop_decider #(.QW(QW), .SHW(SHW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .arr_valid (arr_valid),
        .q_len     (q_len),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .avg_shift (avg_shift),
        .dec_valid (dec_valid),
        .dec_drop  (dec_drop)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish (actual cycles=%0d expected <150000)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit [15:0] rnd_next(input bit [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    // R2 average update, R4..R9 verdict rules.
    function automatic bit model_arrive(input int q, input int lo, input int hi, input int w);
        longint diff, a, lof, hif;
        bit d;
        diff  = (longint'(q) * 256) - m_avg;
        a     = m_avg + (diff >>> w);
        m_avg = a;
        lof   = longint'(lo) * 256;
        hif   = longint'(hi) * 256;
        if (q == 0)            d = 1'b0;
        else if (!(lo < hi))   d = (q >= hi);
        else if (a < lof)      d = 1'b0;
        else if (a >= hif)     d = 1'b1;
        else                   d = (longint'(m_rnd) * (hif - lof)) < ((a - lof) * 65536);
        m_rnd = rnd_next(m_rnd);
        return d;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        arr_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_avg = 0;
        m_rnd = 16'hACE1;
    endtask

    // One isolated arrival followed by an idle cycle; returns the verdict.
    task automatic arrive(input int q, input int lo, input int hi, input int w,
                          output bit got_v, output bit got_d, output bit exp_d);
        @(negedge clk);
        q_len = QW'(q); thr_lo = QW'(lo); thr_hi = QW'(hi); avg_shift = SHW'(w);
        arr_valid = 1'b1;
        exp_d = model_arrive(q, lo, hi, w);
        @(negedge clk);
        arr_valid = 1'b0;
        got_v = dec_valid;
        got_d = dec_drop;
    endtask

    // Table: q, lo, hi, shift, expected (0 admit, 1 drop, 2 model decides)
    localparam int NV = 16;
    localparam logic [53:0] TBL [0:NV-1] = '{
        {16'd0,   16'd10, 16'd20, 4'd0, 2'd0},  // R4 empty
        {16'd5,   16'd10, 16'd20, 4'd0, 2'd0},  // R5 below
        {16'd9,   16'd10, 16'd20, 4'd0, 2'd0},  // R5 just below
        {16'd10,  16'd10, 16'd20, 4'd0, 2'd0},  // R7 equal to lower: never
        {16'd20,  16'd10, 16'd20, 4'd0, 2'd1},  // R6 equal to upper
        {16'd21,  16'd10, 16'd20, 4'd0, 2'd1},  // R6 above
        {16'd100, 16'd10, 16'd20, 4'd0, 2'd1},  // R6 far above
        {16'd15,  16'd10, 16'd20, 4'd0, 2'd2},  // R7 ramp
        {16'd12,  16'd10, 16'd20, 4'd0, 2'd2},  // R7 ramp low
        {16'd18,  16'd10, 16'd20, 4'd0, 2'd2},  // R7 ramp high
        {16'd19,  16'd20, 16'd20, 4'd0, 2'd0},  // R9 equal thresholds, below
        {16'd20,  16'd20, 16'd20, 4'd0, 2'd1},  // R9 equal thresholds, at
        {16'd4,   16'd30, 16'd5,  4'd0, 2'd0},  // R9 reversed, below
        {16'd5,   16'd30, 16'd5,  4'd0, 2'd1},  // R9 reversed, at
        {16'd0,   16'd30, 16'd5,  4'd0, 2'd0},  // R4 empty, reversed
        {16'd16,  16'd10, 16'd20, 4'd0, 2'd2}   // R7 ramp again
    };

    initial begin
        bit gv, gd, ed;
        int drops;

        do_reset();

        // R3 reset state at the outputs
        @(negedge clk);
        check("R3 dec_valid after reset", dec_valid, 0);
        check("R3 dec_drop after reset", dec_drop, 0);
        // R3 average cleared: q=100, shift 15 leaves avg at 0, below lower 1
        arrive(100, 1, 2, 15, gv, gd, ed);
        check("R3 avg zero after reset, admit", gd, 0);
        check("R1 dec_valid after arrival", gv, 1);
        @(negedge clk);
        check("R1 dec_valid low when idle", dec_valid, 0);
        check("R1 dec_drop low when idle", dec_drop, 0);

        // Table walk with zero shift (avg equals q, R2)
        for (int i = 0; i < NV; i++) begin
            logic [53:0] v;
            v = TBL[i];
            arrive(int'(v[53:38]), int'(v[37:22]), int'(v[21:6]), int'(v[5:2]), gv, gd, ed);
            check("R1 table valid", gv, 1);
            if (v[1:0] == 2'd2) begin
                check("R7 R8 table ramp vs model", gd, ed);
            end else begin
                check("R2 R4 R5 R6 R9 table verdict", gd, v[0]);
            end
        end

        // R7 midpoint: probability one half, each verdict against the model
        drops = 0;
        for (int i = 0; i < 200; i++) begin
            arrive(20, 10, 30, 0, gv, gd, ed);
            check("R7 midpoint verdict", gd, ed);
            if (gd) drops++;
        end
        check("R7 midpoint drop fraction in 60..140", (drops >= 60 && drops <= 140), 1);

        // R8: idle stretch must not step the random register
        repeat (7) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            arrive(14, 10, 20, 0, gv, gd, ed);
            check("R8 verdict after idle vs model", gd, ed);
        end

        // R10 burst: back-to-back long-queue arrivals with slow average
        do_reset();
        @(negedge clk);
        q_len = 200; thr_lo = 50; thr_hi = 100; avg_shift = 4;
        arr_valid = 1'b1;
        ed = model_arrive(200, 50, 100, 4);
        for (int i = 0; i < 4; i++) begin
            bit prev;
            prev = ed;
            @(negedge clk);
            check("R1 back-to-back valid", dec_valid, 1);
            check("R10 burst admitted on average", dec_drop, 0);
            check("R10 burst model agrees", dec_drop, prev);
            if (i < 3) ed = model_arrive(200, 50, 100, 4);
            else arr_valid = 1'b0;
        end

        // R2 averaging converges: keep arriving until the model says high
        for (int i = 0; i < 60; i++) begin
            arrive(200, 50, 100, 4, gv, gd, ed);
            check("R2 R7 slow average vs model", gd, ed);
        end
        arrive(200, 50, 100, 4, gv, gd, ed);
        check("R6 average settled above upper", gd, 1);

        // R2 average decays; R4 empty queue still admitted with high average
        arrive(0, 50, 100, 4, gv, gd, ed);
        check("R4 empty with high average", gd, 0);
        for (int i = 0; i < 40; i++) begin
            arrive(1, 50, 100, 3, gv, gd, ed);
            check("R2 decay vs model", gd, ed);
        end
        arrive(1, 50, 100, 3, gv, gd, ed);
        check("R5 average decayed below lower", gd, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule